// File: doc/BRIEF.md
# Wake-Up Event Status Register

This block holds eight sticky flags that record why a system wake-up controller should act. Its causes are a software power-down request, a software power-up request, a watchdog expiry, an interrupt from one of the legacy peripherals or from an external interrupt pin, a mouse interrupt, a keyboard interrupt, a level on a keyboard-controller port pin, and a real-time-clock alarm. Each cause passes through its own wake-enable and module-active gating before it can set a flag. Once set, a flag stays at 1 until the host writes a 1 to its position.

The host clears flags through a write-one-to-clear strobe. The host also writes a companion control byte that carries the power-down and power-up request bits. A secondary management bus can write the same two request bits. While main power is off, the host's power-up request is ignored and only the management bus can raise it. Clearing the alarm flag also sends a one-cycle pulse to a mirrored alarm status bit held in another register. A wake output is high while any flag is set.

Top module: `wake_evt_status`

## Requirements
- R1: After reset, `status` is 0x00 and both `wake` and `rtc_mirror_clr` are 0.
- R2: A high `wdog_evt` sets bit 5 of `status`, and a high `rtc_alarm` sets bit 0, on the next clock edge. Neither input needs an enable.
- R3: Bit 4 sets when, for at least one index i, `legacy_irq[i]`, `legacy_wake_en[i]` and `legacy_active[i]` are all 1. It does not set when any one of the three is 0.
- R4: Bit 4 also sets when `xirq`, `xirq_en` and `xirq_pwake_en` are all 1. It does not set when `xirq` is high and either enable is 0.
- R5: Bit 3 sets only from `mouse_irq` with `mouse_wake_en` and `kbc_active` both high. Bit 2 sets only from `kbd_irq` with `kbd_wake_en` and `kbc_active` both high.
- R6: Bit 1 sets on a high `kbc_pin` only while `kbc_active` is 1.
- R7: A host control write (`host_ctl_wr`) with `host_wdata[7]`=1 sets bit 7. One with `host_wdata[6]`=1 sets bit 6 while `main_pwr_on` is 1. A management write (`mgmt_ctl_wr`) uses `mgmt_ctl_data[1]` to set bit 7 and `mgmt_ctl_data[0]` to set bit 6.
- R8: While `main_pwr_on` is 0, a host power-up request does not set bit 6. A management power-up request does set it.
- R9: A host status write (`host_stat_wr`) clears every bit where `host_wdata` is 1 on the next edge. Bits written with 0 keep their value.
- R10: When a set condition and a clear hit the same bit in the same cycle, the bit stays set. A bit cleared while its qualified source is still high sets again.
- R11: A status write with `host_wdata[0]`=1 makes `rtc_mirror_clr` high for exactly the following cycle. Status writes with bit 0 at 0 leave it low.
- R12: `wake` is 1 exactly when any bit of `status` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_stat_wr | input | 1 | Host write-one-to-clear strobe for the status byte |
| host_ctl_wr | input | 1 | Host write strobe for the control byte |
| host_wdata | input | 8 | Host write data |
| mgmt_ctl_wr | input | 1 | Management bus control write strobe |
| mgmt_ctl_data | input | 2 | Management request bits: [1] power-down, [0] power-up |
| main_pwr_on | input | 1 | Main supply present |
| wdog_evt | input | 1 | Watchdog expiry |
| legacy_irq | input | NUM_LEGACY | Legacy peripheral interrupts |
| legacy_wake_en | input | NUM_LEGACY | Per-peripheral wake enables |
| legacy_active | input | NUM_LEGACY | Per-peripheral active flags |
| xirq | input | 1 | External interrupt pin |
| xirq_en | input | 1 | External interrupt enable |
| xirq_pwake_en | input | 1 | External interrupt power-wake enable |
| mouse_irq | input | 1 | Mouse interrupt |
| mouse_wake_en | input | 1 | Mouse wake enable |
| kbd_irq | input | 1 | Keyboard interrupt |
| kbd_wake_en | input | 1 | Keyboard wake enable |
| kbc_active | input | 1 | Keyboard controller active |
| kbc_pin | input | 1 | Keyboard controller port pin level |
| rtc_alarm | input | 1 | Real-time-clock alarm |
| status | output | 8 | Sticky event flags |
| rtc_mirror_clr | output | 1 | One-cycle clear pulse for the mirrored alarm status |
| wake | output | 1 | Any flag set |

## Verification
The assertions assume that all event, enable and strobe inputs are synchronous to `clk`. They also assume that a flag whose clear is checked has no qualified set condition in that same cycle. The bench drives every input on the falling edge and samples one full cycle later. Where it checks a clear, it drops the source first, except in the one scenario that deliberately overlaps a set with a clear.

// File: rtl/wake_evt_pkg.sv
// Package: bit positions of the wake event flags and of the control byte.
// Assumes an 8-bit status byte; the positions are decoded by software.
package wake_evt_pkg;
    localparam int STAT_W   = 8;
    localparam int B_SWOFF  = 7;
    localparam int B_SWON   = 6;
    localparam int B_WDOG   = 5;
    localparam int B_MOD    = 4;
    localparam int B_MOUSE  = 3;
    localparam int B_KBD    = 2;
    localparam int B_PIN    = 1;
    localparam int B_RTC    = 0;
    // control byte request positions on the host bus
    localparam int C_OFF    = 7;
    localparam int C_ON     = 6;
    // management request positions
    localparam int M_OFF    = 1;
    localparam int M_ON     = 0;
endpackage

// File: rtl/wake_evt_qual.sv
// Module: combines raw interrupt and pin sources with their enables and
// module-active flags into per-flag set requests for the hardware causes.
// Assumes all inputs are synchronous to the block clock; purely combinational.
module wake_evt_qual #(
    parameter int NUM_LEGACY = 4
) (
    input  logic [NUM_LEGACY-1:0] legacy_irq,
    input  logic [NUM_LEGACY-1:0] legacy_wake_en,
    input  logic [NUM_LEGACY-1:0] legacy_active,
    input  logic                  xirq,
    input  logic                  xirq_en,
    input  logic                  xirq_pwake_en,
    input  logic                  mouse_irq,
    input  logic                  mouse_wake_en,
    input  logic                  kbd_irq,
    input  logic                  kbd_wake_en,
    input  logic                  kbc_active,
    input  logic                  kbc_pin,
    output logic                  set_mod,
    output logic                  set_mouse,
    output logic                  set_kbd,
    output logic                  set_pin
);
    logic [NUM_LEGACY-1:0] leg_hit;

    // per-peripheral triple qualification
    for (genvar i = 0; i < NUM_LEGACY; i++) begin : g_leg
        assign leg_hit[i] = legacy_irq[i] & legacy_wake_en[i] & legacy_active[i];
    end

    // merge legacy and external pin into one module flag; keyboard controller sources
    always_comb begin
        set_mod   = (|leg_hit) | (xirq & xirq_en & xirq_pwake_en);
        set_mouse = mouse_irq & mouse_wake_en & kbc_active;
        set_kbd   = kbd_irq & kbd_wake_en & kbc_active;
        set_pin   = kbc_pin & kbc_active;
    end
endmodule

// File: rtl/wake_pwr_req_gate.sv
// Module: turns control-byte writes from the host and management buses into
// power-down and power-up set requests. A host power-up request is refused
// while main power is off; the management bus is always accepted.
// Assumes write strobes are single-cycle or level; each high cycle is a request.
module wake_pwr_req_gate (
    input  logic host_ctl_wr,
    input  logic host_off_bit,
    input  logic host_on_bit,
    input  logic mgmt_ctl_wr,
    input  logic mgmt_off_bit,
    input  logic mgmt_on_bit,
    input  logic main_pwr_on,
    output logic set_off,
    output logic set_on
);
    logic host_on_ok;

    // power-up from the host needs main power present
    always_comb begin
        host_on_ok = host_ctl_wr & host_on_bit & main_pwr_on;
        set_on     = host_on_ok | (mgmt_ctl_wr & mgmt_on_bit);
        set_off    = (host_ctl_wr & host_off_bit) | (mgmt_ctl_wr & mgmt_off_bit);
    end
endmodule

// File: rtl/wake_evt_sticky.sv
// Module: a row of sticky flags with write-one-to-clear, where a set
// request outranks a clear in the same cycle.
// Assumes synchronous active-low reset to all zeros.
module wake_evt_sticky #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        // hold, clear on request, set takes priority
        always_ff @(posedge clk) begin
            if (!rst_n)          q[b] <= 1'b0;
            else if (set_vec[b]) q[b] <= 1'b1;
            else if (clr_vec[b]) q[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/wake_evt_status.sv
// Module: top of the wake event status register. Qualifies every wake cause,
// latches it in a sticky flag, clears flags on host write-one-to-clear, pulses
// a clear to the mirrored alarm status, and raises wake while any flag is set.
// Assumes all inputs synchronous to clk; synchronous active-low reset.
module wake_evt_status
    import wake_evt_pkg::*;
#(
    parameter int NUM_LEGACY = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_stat_wr,
    input  logic                  host_ctl_wr,
    input  logic [STAT_W-1:0]     host_wdata,
    input  logic                  mgmt_ctl_wr,
    input  logic [1:0]            mgmt_ctl_data,
    input  logic                  main_pwr_on,
    input  logic                  wdog_evt,
    input  logic [NUM_LEGACY-1:0] legacy_irq,
    input  logic [NUM_LEGACY-1:0] legacy_wake_en,
    input  logic [NUM_LEGACY-1:0] legacy_active,
    input  logic                  xirq,
    input  logic                  xirq_en,
    input  logic                  xirq_pwake_en,
    input  logic                  mouse_irq,
    input  logic                  mouse_wake_en,
    input  logic                  kbd_irq,
    input  logic                  kbd_wake_en,
    input  logic                  kbc_active,
    input  logic                  kbc_pin,
    input  logic                  rtc_alarm,
    output logic [STAT_W-1:0]     status,
    output logic                  rtc_mirror_clr,
    output logic                  wake
);
    logic              set_mod, set_mouse, set_kbd, set_pin;
    logic              set_off, set_on;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;

    wake_evt_qual #(.NUM_LEGACY(NUM_LEGACY)) u_qual (
        .legacy_irq    (legacy_irq),
        .legacy_wake_en(legacy_wake_en),
        .legacy_active (legacy_active),
        .xirq          (xirq),
        .xirq_en       (xirq_en),
        .xirq_pwake_en (xirq_pwake_en),
        .mouse_irq     (mouse_irq),
        .mouse_wake_en (mouse_wake_en),
        .kbd_irq       (kbd_irq),
        .kbd_wake_en   (kbd_wake_en),
        .kbc_active    (kbc_active),
        .kbc_pin       (kbc_pin),
        .set_mod       (set_mod),
        .set_mouse     (set_mouse),
        .set_kbd       (set_kbd),
        .set_pin       (set_pin)
    );

    wake_pwr_req_gate u_gate (
        .host_ctl_wr (host_ctl_wr),
        .host_off_bit(host_wdata[C_OFF]),
        .host_on_bit (host_wdata[C_ON]),
        .mgmt_ctl_wr (mgmt_ctl_wr),
        .mgmt_off_bit(mgmt_ctl_data[M_OFF]),
        .mgmt_on_bit (mgmt_ctl_data[M_ON]),
        .main_pwr_on (main_pwr_on),
        .set_off     (set_off),
        .set_on      (set_on)
    );

    // assemble per-flag set and clear vectors
    always_comb begin
        set_vec          = '0;
        set_vec[B_SWOFF] = set_off;
        set_vec[B_SWON]  = set_on;
        set_vec[B_WDOG]  = wdog_evt;
        set_vec[B_MOD]   = set_mod;
        set_vec[B_MOUSE] = set_mouse;
        set_vec[B_KBD]   = set_kbd;
        set_vec[B_PIN]   = set_pin;
        set_vec[B_RTC]   = rtc_alarm;
        clr_vec          = host_stat_wr ? host_wdata : '0;
    end

    wake_evt_sticky #(.W(STAT_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .q      (status)
    );

    // one-cycle clear pulse toward the mirrored alarm status
    always_ff @(posedge clk) begin
        if (!rst_n) rtc_mirror_clr <= 1'b0;
        else        rtc_mirror_clr <= clr_vec[B_RTC];
    end

    // wake request while anything is pending
    always_comb wake = |status;
endmodule

// File: rtl/wake_evt_status_chk.sv
// Module: property checker for wake_evt_status, attached by bind.
// Assumes inputs are synchronous to clk; every property is disabled in reset.
module wake_evt_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_stat_wr,
    input logic       host_ctl_wr,
    input logic [7:0] host_wdata,
    input logic       mgmt_ctl_wr,
    input logic       main_pwr_on,
    input logic       wdog_evt,
    input logic       kbd_irq,
    input logic       kbd_wake_en,
    input logic       kbc_active,
    input logic       kbc_pin,
    input logic [7:0] status,
    input logic       rtc_mirror_clr,
    input logic       wake
);
    AST_WDOG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_evt |=> status[5]); // R2
    AST_KBD_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_irq && kbd_wake_en && kbc_active) |=> status[2]); // R10
    AST_PIN_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!kbc_active && !status[1]) |=> !status[1]); // R6
    AST_PWRON_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_pwr_on && !mgmt_ctl_wr && !status[6]) |=> !status[6]); // R8
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        host_stat_wr |=> ((($past(status) & ~$past(host_wdata)) & ~status) == 8'h00)); // R9
    AST_WDOG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stat_wr && host_wdata[5] && !wdog_evt) |=> !status[5]); // R9
    AST_MIRROR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stat_wr && host_wdata[0]) |=> rtc_mirror_clr); // R11
    AST_MIRROR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_stat_wr && host_wdata[0]) |=> !rtc_mirror_clr); // R11
    AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !host_stat_wr) |=> wake); // R12
    AST_CTL_OFF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ctl_wr && host_wdata[7]) |=> status[7]); // R7
endmodule

bind wake_evt_status wake_evt_status_chk u_chk (.*);

// File: tb/wake_evt_status_test.sv
module wake_evt_status_test;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_stat_wr = 0, host_ctl_wr = 0, mgmt_ctl_wr = 0;
    logic [7:0]    host_wdata = 0;
    logic [1:0]    mgmt_ctl_data = 0;
    logic          main_pwr_on = 1;
    logic          wdog_evt = 0, xirq = 0, xirq_en = 0, xirq_pwake_en = 0;
    logic [NL-1:0] legacy_irq = 0, legacy_wake_en = 0, legacy_active = 0;
    logic          mouse_irq = 0, mouse_wake_en = 0, kbd_irq = 0, kbd_wake_en = 0;
    logic          kbc_active = 0, kbc_pin = 0, rtc_alarm = 0;
    logic [7:0]    status;
    logic          rtc_mirror_clr, wake;

    int n_chk = 0;
    int n_fail = 0;

    wake_evt_status #(.NUM_LEGACY(NL)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // advance one full cycle: inputs set at a falling edge are captured at the rising edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_all();
        host_stat_wr = 1; host_wdata = 8'hFF; step();
        host_stat_wr = 0; host_wdata = 8'h00; step();
    endtask

    task automatic t_reset();
        check("R1 status", status, 8'h00);
        check("R1 wake", {7'b0, wake}, 8'h00);
        check("R1 mirror", {7'b0, rtc_mirror_clr}, 8'h00);
    endtask

    task automatic t_wdog_rtc();
        wdog_evt = 1; step(); wdog_evt = 0;
        check("R2 wdog", status, 8'h20);
        check("R12 wake on", {7'b0, wake}, 8'h01);
        rtc_alarm = 1; step(); rtc_alarm = 0;
        check("R2 rtc", status, 8'h21);
        clear_all();
        check("R12 wake off", {7'b0, wake}, 8'h00);
    endtask

    task automatic t_legacy();
        legacy_irq = 4'b0010; legacy_wake_en = 4'b0010; legacy_active = 4'b0000; step();
        check("R3 inactive", status, 8'h00);
        legacy_active = 4'b1101; step();
        check("R3 other active", status, 8'h00);
        legacy_active = 4'b0010; step();
        check("R3 qualified", status, 8'h10);
        legacy_irq = 0; legacy_wake_en = 0; legacy_active = 0;
        clear_all();
    endtask

    task automatic t_xirq();
        xirq = 1; xirq_en = 1; xirq_pwake_en = 0; step();
        check("R4 no pwake", status, 8'h00);
        xirq_en = 0; xirq_pwake_en = 1; step();
        check("R4 no en", status, 8'h00);
        xirq_en = 1; step();
        check("R4 both", status, 8'h10);
        xirq = 0; xirq_en = 0; xirq_pwake_en = 0;
        clear_all();
    endtask

    task automatic t_kbc();
        mouse_irq = 1; mouse_wake_en = 1; kbd_irq = 1; kbd_wake_en = 1; kbc_pin = 1; step();
        check("R5 R6 kbc inactive", status, 8'h00);
        kbd_wake_en = 0; kbc_pin = 0; kbc_active = 1; step();
        check("R5 mouse", status, 8'h08);
        mouse_irq = 0; kbd_wake_en = 1; step();
        check("R5 kbd", status, 8'h0C);
        kbd_irq = 0; kbc_pin = 1; step();
        check("R6 pin", status, 8'h0E);
        kbc_pin = 0; kbc_active = 0; mouse_wake_en = 0; kbd_wake_en = 0;
        clear_all();
    endtask

    task automatic t_ctl();
        main_pwr_on = 1;
        host_ctl_wr = 1; host_wdata = 8'h80; step();
        check("R7 host off", status, 8'h80);
        host_wdata = 8'h40; step();
        host_ctl_wr = 0; host_wdata = 0;
        check("R7 host on", status, 8'hC0);
        clear_all();
        mgmt_ctl_wr = 1; mgmt_ctl_data = 2'b10; step();
        mgmt_ctl_wr = 0; mgmt_ctl_data = 0;
        check("R7 mgmt off", status, 8'h80);
        clear_all();
    endtask

    task automatic t_gate();
        main_pwr_on = 0;
        host_ctl_wr = 1; host_wdata = 8'h40; step();
        host_ctl_wr = 0; host_wdata = 0;
        check("R8 host refused", status, 8'h00);
        mgmt_ctl_wr = 1; mgmt_ctl_data = 2'b01; step();
        mgmt_ctl_wr = 0; mgmt_ctl_data = 0;
        check("R8 mgmt accepted", status, 8'h40);
        main_pwr_on = 1;
        clear_all();
    endtask

    task automatic t_w1c();
        wdog_evt = 1; kbd_irq = 1; kbd_wake_en = 1; kbc_active = 1; step();
        wdog_evt = 0; kbd_irq = 0;
        check("R9 setup", status, 8'h24);
        host_stat_wr = 1; host_wdata = 8'h00; step();
        check("R9 zero write", status, 8'h24);
        host_wdata = 8'h04; step();
        host_stat_wr = 0; host_wdata = 0;
        check("R9 clear one", status, 8'h20);
        kbd_wake_en = 0; kbc_active = 0;
        clear_all();
    endtask

    task automatic t_set_wins();
        wdog_evt = 1; step();
        host_stat_wr = 1; host_wdata = 8'h20; step();
        check("R10 set beats clear", status, 8'h20);
        wdog_evt = 0; step();
        host_stat_wr = 0; host_wdata = 0;
        check("R10 clear after release", status, 8'h00);
        kbd_irq = 1; kbd_wake_en = 1; kbc_active = 1; step();
        host_stat_wr = 1; host_wdata = 8'h04; step();
        host_stat_wr = 0; host_wdata = 0; step();
        check("R10 level resets", status, 8'h04);
        kbd_irq = 0; kbd_wake_en = 0; kbc_active = 0;
        clear_all();
    endtask

    task automatic t_mirror();
        rtc_alarm = 1; step(); rtc_alarm = 0;
        host_stat_wr = 1; host_wdata = 8'h02; step();
        check("R11 no pulse bit1", {7'b0, rtc_mirror_clr}, 8'h00);
        check("R11 alarm kept", status, 8'h01);
        host_wdata = 8'h01; step();
        host_stat_wr = 0; host_wdata = 0;
        check("R11 pulse", {7'b0, rtc_mirror_clr}, 8'h01);
        check("R11 alarm cleared", status, 8'h00);
        step();
        check("R11 pulse ends", {7'b0, rtc_mirror_clr}, 8'h00);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) step();
        rst_n = 1; step();
        t_reset();
        t_wdog_rtc();
        t_legacy();
        t_xirq();
        t_kbc();
        t_ctl();
        t_gate();
        t_w1c();
        t_set_wins();
        t_mirror();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule